// File: doc/BRIEF.md
# Serial Command Decoder with Configuration, LED and Byte Data Port

This block is a slave on a four-wire serial bus that uses clock polarity 0 and phase 0. At the start of every select it takes one command byte. That byte chooses what the rest of the select does:

- load an 8-bit configuration register that drives status outputs,
- turn an auxiliary LED on or off,
- stream bytes out to a byte-wide data port using a write strobe, or
- fetch bytes from that port with a read strobe and shift them back to the master.

Write payload can arrive two bits per clock. The high bit of each pair comes on the normal data input and the low bit comes on an extra input line.

All bus pins are passed through synchronizers and handled in the system clock domain. Each serial clock half-period must therefore last at least `SYNC_STAGES + 4` system clocks. Read data is fetched from the port while the byte before it completes, so the data bytes follow one another on the return line with no gap. A write payload is held back by one byte. The master ends every write with one idle byte, and this scheme is what lets that byte be dropped.

Top module: `spicmd_slave`

## Requirements
- R1: Input bits are sampled on rising serial-clock edges, most significant bit first. The command byte is always taken one bit per clock. The return line changes only after falling edges.
- R2: Command 0x09 copies the next byte into the configuration register `cfg_q`. Any further bytes in the same select leave it unchanged.
- R3: After reset the outputs are as follows:
  - `cfg_q` is 8'hFF.
  - `user_led_n` (mirrors `cfg_q[3:0]`) reads 4'hF.
  - `nand_ce_n` (mirrors `cfg_q[4]`) is 1.
  - `led5_n` is 1.
  - `spi_miso` is 0.
  - No strobe is active.
- R4: Command 0x0C drives `led5_n` low and command 0x0D drives it high. Neither command changes `cfg_q`.
- R5: After command 0x08, every byte uses two bits per clock, in the order 7:6, 5:4, 3:2, 1:0. The higher bit of each pair is on `spi_mosi` and the lower bit is on `spi_aux`.
- R6: Each byte after 0x08 is written when the byte that follows it completes. The write is a one-cycle `nand_wr` pulse with `nand_wdata` holding that byte. The last byte before deselect is the trailing idle byte, and it is never written.
- R7: Command 0x0A is followed by one idle byte and then data bytes. A one-cycle `nand_rd` pulse is issued at the end of the idle byte and at the end of each data byte. `nand_rdata` is sampled on the clock edge that ends the pulse. The data goes out MSB first with no gap between bytes, and the return line is 0 during all other bytes.
- R8: Command 0x0B behaves like 0x0A, except that four idle bytes come before the read data.
- R9: Raising chip select discards any partial byte and any held write byte. The next select starts by decoding a new command.
- R10: A command byte not listed above makes every later byte of that select have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_csn | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in; high bit of each pair in two-bit mode |
| spi_aux | input | 1 | Low bit of each pair in two-bit mode |
| spi_miso | output | 1 | Serial data out |
| cfg_q | output | 8 | Configuration register |
| user_led_n | output | 4 | Active-low user LEDs, `cfg_q[3:0]` |
| nand_ce_n | output | 1 | Active-low data-port chip enable, `cfg_q[4]` |
| led5_n | output | 1 | Active-low auxiliary LED |
| nand_wdata | output | 8 | Write data, valid with `nand_wr` |
| nand_wr | output | 1 | One-cycle write strobe |
| nand_rdata | input | 8 | Read data, sampled at the end of `nand_rd` |
| nand_rd | output | 1 | One-cycle read strobe |

## Verification
All 256 command values are sent, each followed by one byte in the framing the command implies. This sweep separates the six defined commands from the rest: only 0x09 changes the register, only 0x0C and 0x0D move the LED, only 0x0A issues a read after a single byte, and 0x08 produces no write because its lone byte is the idle byte. Directed streams then check the following:
- Dual-bit payloads whose bit pairs are asymmetric, so a swapped pair order or swapped lines shows up.
- Reads after one idle byte and after four, which exposes a wrong idle count or a gap in the data.
- Selects cut off in the middle of a byte, which shows whether the decoder truly restarts.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

    localparam int BYTE_W = 8;

    // Command byte values
    localparam logic [BYTE_W-1:0] OP_PORT_WRITE = 8'h08;
    localparam logic [BYTE_W-1:0] OP_CFG_LOAD   = 8'h09;
    localparam logic [BYTE_W-1:0] OP_PORT_READ  = 8'h0A;
    localparam logic [BYTE_W-1:0] OP_FAST_READ  = 8'h0B;
    localparam logic [BYTE_W-1:0] OP_LED_ON     = 8'h0C;
    localparam logic [BYTE_W-1:0] OP_LED_OFF    = 8'h0D;

    // Configuration field layout
    localparam int NUM_USER_LEDS = 4;
    localparam int CFG_CE_BIT    = 4;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_CFG,
        ST_WRITE,
        ST_RD_IDLE,
        ST_RD_DATA,
        ST_DONE
    } seq_state_e;

    // One write byte held until the next one proves it was not the idle byte
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } held_byte_t;

    // Number of idle bytes that precede read data for a read command
    function automatic int lead_idle_bytes(input logic [BYTE_W-1:0] op,
                                           input int fast_idle);
        return (op == OP_FAST_READ) ? fast_idle : 1;
    endfunction

endpackage

// File: rtl/spicmd_pin_sync.sv
module spicmd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    input  logic mosi,
    input  logic aux,
    output logic sck_rise,
    output logic sck_fall,
    output logic csn_s,
    output logic mosi_s,
    output logic aux_s
);
    // bit 0 sck, bit 1 csn, bit 2 mosi, bit 3 aux
    localparam int NPIN = 4;
    localparam logic [NPIN-1:0] RST_VEC = 4'b0010;

    logic [STAGES-1:0][NPIN-1:0] chain;
    logic sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VEC;
            sck_prev <= 1'b0;
        end else begin
            chain[0] <= {aux, mosi, csn, sck};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            sck_prev <= chain[STAGES-1][0];
        end
    end

    assign sck_rise = chain[STAGES-1][0] & ~sck_prev;
    assign sck_fall = ~chain[STAGES-1][0] & sck_prev;
    assign csn_s    = chain[STAGES-1][1];
    assign mosi_s   = chain[STAGES-1][2];
    assign aux_s    = chain[STAGES-1][3];
endmodule

// File: rtl/spicmd_rx_shift.sv
module spicmd_rx_shift
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              dual,
    input  logic              mosi,
    input  logic              aux,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_q,
    output logic              at_boundary
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;

    logic [BYTE_W-1:0] sr, sr_next;
    logic [CNT_W-1:0]  cnt, cnt_next;

    always_comb begin
        if (dual) begin
            sr_next  = {sr[BYTE_W-3:0], mosi, aux};
            cnt_next = cnt + CNT_W'(2);
        end else begin
            sr_next  = {sr[BYTE_W-2:0], mosi};
            cnt_next = cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sr        <= '0;
            cnt       <= '0;
            byte_done <= 1'b0;
            if (rst) byte_q <= '0;
        end else begin
            byte_done <= 1'b0;
            if (rise) begin
                sr <= sr_next;
                if (cnt_next >= CNT_W'(BYTE_W)) begin
                    cnt       <= '0;
                    byte_done <= 1'b1;
                    byte_q    <= sr_next;
                end else begin
                    cnt <= cnt_next;
                end
            end
        end
    end

    assign at_boundary = (cnt == '0);
endmodule

// File: rtl/spicmd_tx_shift.sv
module spicmd_tx_shift
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              fall,
    input  logic              boundary,
    input  logic              load_en,
    input  logic [BYTE_W-1:0] load_val,
    output logic              miso
);
    logic [BYTE_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sr <= '0;
        end else if (fall) begin
            if (boundary) sr <= load_en ? load_val : '0;
            else          sr <= {sr[BYTE_W-2:0], 1'b0};
        end
    end

    assign miso = sr[BYTE_W-1];
endmodule

// File: rtl/spicmd_sequencer.sv
module spicmd_sequencer
    import spicmd_pkg::*;
#(
    parameter int                FAST_IDLE_BYTES = 4,
    parameter logic [BYTE_W-1:0] CFG_RESET       = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] nand_rdata,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              led5_n,
    output logic              dual_mode,
    output logic              nand_wr,
    output logic [BYTE_W-1:0] nand_wdata,
    output logic              nand_rd,
    output logic              tx_load_en,
    output logic [BYTE_W-1:0] tx_load_val
);
    localparam int IDLE_W = $clog2(FAST_IDLE_BYTES + 1);

    seq_state_e        state;
    logic [IDLE_W-1:0] idle_left;
    held_byte_t        held;
    logic [BYTE_W-1:0] rd_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_OPCODE;
            cfg_q      <= CFG_RESET;
            led5_n     <= 1'b1;
            idle_left  <= '0;
            held       <= '0;
            nand_wr    <= 1'b0;
            nand_wdata <= '0;
            nand_rd    <= 1'b0;
            rd_buf     <= '0;
        end else begin
            nand_wr <= 1'b0;
            nand_rd <= 1'b0;
            if (nand_rd) rd_buf <= nand_rdata;
            if (!active) begin
                state      <= ST_OPCODE;
                held.valid <= 1'b0;
            end else if (byte_done) begin
                unique case (state)
                    ST_OPCODE: begin
                        unique case (byte_in)
                            OP_CFG_LOAD:   state <= ST_CFG;
                            OP_LED_ON:     begin led5_n <= 1'b0; state <= ST_DONE; end
                            OP_LED_OFF:    begin led5_n <= 1'b1; state <= ST_DONE; end
                            OP_PORT_WRITE: begin state <= ST_WRITE; held.valid <= 1'b0; end
                            OP_PORT_READ, OP_FAST_READ: begin
                                idle_left <= IDLE_W'(lead_idle_bytes(byte_in, FAST_IDLE_BYTES) - 1);
                                state     <= ST_RD_IDLE;
                            end
                            default:       state <= ST_DONE;
                        endcase
                    end
                    ST_CFG: begin
                        cfg_q <= byte_in;
                        state <= ST_DONE;
                    end
                    ST_WRITE: begin
                        if (held.valid) begin
                            nand_wr    <= 1'b1;
                            nand_wdata <= held.data;
                        end
                        held <= '{valid: 1'b1, data: byte_in};
                    end
                    ST_RD_IDLE: begin
                        if (idle_left == '0) begin
                            state   <= ST_RD_DATA;
                            nand_rd <= 1'b1;
                        end else begin
                            idle_left <= idle_left - IDLE_W'(1);
                        end
                    end
                    ST_RD_DATA: nand_rd <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign dual_mode   = (state == ST_WRITE);
    assign tx_load_en  = (state == ST_RD_DATA);
    assign tx_load_val = rd_buf;
endmodule

// File: rtl/spicmd_slave.sv
module spicmd_slave
    import spicmd_pkg::*;
#(
    parameter int                SYNC_STAGES     = 2,
    parameter int                FAST_IDLE_BYTES = 4,
    parameter logic [BYTE_W-1:0] CFG_RESET       = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     spi_sck,
    input  logic                     spi_csn,
    input  logic                     spi_mosi,
    input  logic                     spi_aux,
    output logic                     spi_miso,
    output logic [BYTE_W-1:0]        cfg_q,
    output logic [NUM_USER_LEDS-1:0] user_led_n,
    output logic                     nand_ce_n,
    output logic                     led5_n,
    output logic [BYTE_W-1:0]        nand_wdata,
    output logic                     nand_wr,
    input  logic [BYTE_W-1:0]        nand_rdata,
    output logic                     nand_rd
);
    logic sck_rise, sck_fall, csn_s, mosi_s, aux_s;
    logic byte_done, at_boundary, dual_mode, tx_load_en;
    logic [BYTE_W-1:0] rx_byte, tx_load_val;

    spicmd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck(spi_sck), .csn(spi_csn), .mosi(spi_mosi), .aux(spi_aux),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .csn_s(csn_s), .mosi_s(mosi_s), .aux_s(aux_s)
    );

    spicmd_rx_shift u_rx (
        .clk(clk), .rst(rst), .active(~csn_s), .rise(sck_rise),
        .dual(dual_mode), .mosi(mosi_s), .aux(aux_s),
        .byte_done(byte_done), .byte_q(rx_byte), .at_boundary(at_boundary)
    );

    spicmd_sequencer #(
        .FAST_IDLE_BYTES(FAST_IDLE_BYTES),
        .CFG_RESET(CFG_RESET)
    ) u_seq (
        .clk(clk), .rst(rst), .active(~csn_s),
        .byte_done(byte_done), .byte_in(rx_byte), .nand_rdata(nand_rdata),
        .cfg_q(cfg_q), .led5_n(led5_n), .dual_mode(dual_mode),
        .nand_wr(nand_wr), .nand_wdata(nand_wdata), .nand_rd(nand_rd),
        .tx_load_en(tx_load_en), .tx_load_val(tx_load_val)
    );

    spicmd_tx_shift u_tx (
        .clk(clk), .rst(rst), .active(~csn_s), .fall(sck_fall),
        .boundary(at_boundary), .load_en(tx_load_en), .load_val(tx_load_val),
        .miso(spi_miso)
    );

    assign user_led_n = cfg_q[NUM_USER_LEDS-1:0];
    assign nand_ce_n  = cfg_q[CFG_CE_BIT];
endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker #(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  CFG_RESET   = 8'hFF
) (
    input logic       clk,
    input logic       rst,
    input logic       spi_csn,
    input logic       spi_miso,
    input logic       nand_wr,
    input logic       nand_rd,
    input logic       led5_n,
    input logic [7:0] cfg_q
);
    localparam int QUIET = SYNC_STAGES + 3;
    localparam int CW    = $clog2(QUIET + 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !spi_csn)          hi_cnt <= '0;
        else if (int'(hi_cnt) < QUIET) hi_cnt <= hi_cnt + CW'(1);
    end

    assert_reset_state_R3: assert property (@(posedge clk)
        rst |=> (cfg_q == CFG_RESET && led5_n && !nand_wr && !nand_rd));

    assert_wr_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        nand_wr |=> !nand_wr);

    assert_rd_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        nand_rd |=> !nand_rd);

    // R6 and R7: never a write and a read in the same cycle
    assert_strobe_apart_R7: assert property (@(posedge clk) disable iff (rst)
        !(nand_wr && nand_rd));

    assert_led_keeps_cfg_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(led5_n) |-> $stable(cfg_q));

    assert_quiet_deselect_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(hi_cnt) == QUIET) |-> (!spi_miso && !nand_wr && !nand_rd));
endmodule

bind spicmd_slave spicmd_checker #(
    .SYNC_STAGES(SYNC_STAGES),
    .CFG_RESET(CFG_RESET)
) u_checker (
    .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_miso(spi_miso),
    .nand_wr(nand_wr), .nand_rd(nand_rd), .led5_n(led5_n), .cfg_q(cfg_q)
);

// File: tb/spicmd_slave_test.sv
module spicmd_slave_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, aux = 1'b0;
    logic miso, led5_n, nand_ce_n, nand_wr, nand_rd;
    logic [7:0] cfg_q, nand_wdata, nand_rdata;
    logic [3:0] user_led_n;

    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [7:0] wlog [0:15];
    bit done = 0;

    always #10 clk = ~clk;

    spicmd_slave uut (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
        .spi_aux(aux), .spi_miso(miso), .cfg_q(cfg_q), .user_led_n(user_led_n),
        .nand_ce_n(nand_ce_n), .led5_n(led5_n), .nand_wdata(nand_wdata),
        .nand_wr(nand_wr), .nand_rdata(nand_rdata), .nand_rd(nand_rd)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign nand_rdata = pat(rd_cnt);

    always @(posedge clk) begin
        if (nand_wr) begin
            wlog[wr_cnt % 16] <= nand_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (nand_rd) rd_cnt <= rd_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_begin;
        csn = 1'b0;
        wait_clks(HALF);
    endtask

    task automatic sel_end;
        wait_clks(HALF);
        csn = 1'b1;
        mosi = 1'b0;
        aux = 1'b0;
        wait_clks(2 * HALF);
    endtask

    // Send nclk clocks of a byte; dual carries two bits per clock
    task automatic xfer(input logic [7:0] tx, input bit dual, input int nclk,
                        output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nclk; i++) begin
            if (dual) begin
                mosi = tx[7 - 2*i];
                aux  = tx[6 - 2*i];
            end else begin
                mosi = tx[7 - i];
                aux  = 1'b0;
            end
            wait_clks(HALF);
            rx = {rx[6:0], miso};
            sck = 1'b1;
            wait_clks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
        xfer(tx, 1'b0, 8, rx);
    endtask

    task automatic dbyte(input logic [7:0] tx);
        logic [7:0] r;
        xfer(tx, 1'b1, 4, r);
    endtask

    initial begin
        logic [7:0] r, r2;
        logic [7:0] exp_cfg;
        logic       exp_led;
        logic [7:0] payload [0:3];
        int w0, r0;
        bit ok;

        wait_clks(5);
        rst = 1'b0;
        wait_clks(3);

        // R3 reset state
        check(cfg_q == 8'hFF, "R3 cfg_q", cfg_q, 8'hFF);
        check(user_led_n == 4'hF && nand_ce_n && led5_n, "R3 leds/ce",
              {user_led_n, nand_ce_n, led5_n}, 6'h3F);
        check(!miso && wr_cnt == 0 && rd_cnt == 0, "R3 miso/strobes",
              {miso, 8'(wr_cnt), 8'(rd_cnt)}, 0);

        // R1 R10 exhaustive command sweep, each with one following byte
        exp_cfg = 8'hFF;
        exp_led = 1'b1;
        for (int op = 0; op < 256; op++) begin
            w0 = wr_cnt;
            r0 = rd_cnt;
            sel_begin();
            sbyte(8'(op), r);
            if (op == 8'h08) begin dbyte(8'(op) ^ 8'hA5); r2 = 8'h00; end
            else sbyte(8'(op) ^ 8'hA5, r2);
            sel_end();
            if (op == 8'h09) exp_cfg = 8'(op) ^ 8'hA5;
            if (op == 8'h0C) exp_led = 1'b0;
            if (op == 8'h0D) exp_led = 1'b1;
            ok = (cfg_q == exp_cfg) && (led5_n == exp_led) && (wr_cnt == w0) &&
                 (rd_cnt - r0 == ((op == 8'h0A) ? 1 : 0)) && r == 8'h00 && r2 == 8'h00;
            check(ok, $sformatf("R10 R1 sweep op=%02h", op),
                  {cfg_q, 7'(rd_cnt - r0), led5_n}, {exp_cfg, 7'((op == 8'h0A) ? 1 : 0), exp_led});
        end

        // R2 configuration load and ignore of trailing bytes
        sel_begin(); sbyte(8'h09, r); sbyte(8'hA5, r); sel_end();
        check(cfg_q == 8'hA5, "R2 cfg load", cfg_q, 8'hA5);
        check(user_led_n == 4'h5 && nand_ce_n == 1'b0, "R3 cfg field map",
              {user_led_n, nand_ce_n}, 5'h0A);
        sel_begin(); sbyte(8'h09, r); sbyte(8'h3C, r); sbyte(8'hC3, r); sel_end();
        check(cfg_q == 8'h3C, "R2 extra byte ignored", cfg_q, 8'h3C);

        // R4 LED on/off keep configuration
        sel_begin(); sbyte(8'h0C, r); sel_end();
        check(led5_n == 1'b0 && cfg_q == 8'h3C, "R4 led on", {led5_n, cfg_q}, 9'h03C);
        sel_begin(); sbyte(8'h0D, r); sel_end();
        check(led5_n == 1'b1 && cfg_q == 8'h3C, "R4 led off", {led5_n, cfg_q}, 9'h13C);

        // R5 R6 dual-bit write stream with trailing idle byte
        payload[0] = 8'h11; payload[1] = 8'h2D; payload[2] = 8'hC3; payload[3] = 8'h7E;
        w0 = wr_cnt;
        sel_begin(); sbyte(8'h08, r);
        for (int i = 0; i < 4; i++) dbyte(payload[i]);
        dbyte(8'hFF);
        sel_end();
        check(wr_cnt - w0 == 4, "R6 write count", wr_cnt - w0, 4);
        for (int i = 0; i < 4; i++)
            check(wlog[(w0 + i) % 16] == payload[i], $sformatf("R5 write data %0d", i),
                  wlog[(w0 + i) % 16], payload[i]);

        // R7 read after one idle byte
        r0 = rd_cnt;
        sel_begin(); sbyte(8'h0A, r); sbyte(8'h00, r2);
        check(r2 == 8'h00, "R7 idle byte quiet", r2, 0);
        for (int i = 0; i < 3; i++) begin
            sbyte(8'h00, r);
            check(r == pat(r0 + i), $sformatf("R7 read data %0d", i), r, pat(r0 + i));
        end
        sel_end();
        check(rd_cnt - r0 == 4, "R7 read strobes", rd_cnt - r0, 4);

        // R8 fast read after four idle bytes
        r0 = rd_cnt;
        sel_begin(); sbyte(8'h0B, r);
        for (int i = 0; i < 4; i++) begin
            sbyte(8'h00, r2);
            check(r2 == 8'h00 && (i == 3 ? rd_cnt - r0 == 1 : rd_cnt == r0),
                  $sformatf("R8 idle %0d", i), {r2, 8'(rd_cnt - r0)}, 0);
        end
        for (int i = 0; i < 2; i++) begin
            sbyte(8'h00, r);
            check(r == pat(r0 + i), $sformatf("R8 read data %0d", i), r, pat(r0 + i));
        end
        sel_end();

        // R9 abort inside a configuration byte, then a fresh command
        sel_begin(); sbyte(8'h09, r); xfer(8'h00, 1'b0, 4, r); sel_end();
        check(cfg_q == 8'h3C, "R9 partial cfg discarded", cfg_q, 8'h3C);
        sel_begin(); sbyte(8'h0C, r); sel_end();
        check(led5_n == 1'b0, "R9 fresh command decoded", led5_n, 0);

        // R9 abort inside a write stream drops held and partial bytes
        w0 = wr_cnt;
        sel_begin(); sbyte(8'h08, r); dbyte(8'h66); dbyte(8'h99);
        xfer(8'hF0, 1'b1, 2, r); sel_end();
        check(wr_cnt - w0 == 1 && wlog[w0 % 16] == 8'h66, "R9 write abort",
              {8'(wr_cnt - w0), wlog[w0 % 16]}, 16'h0166);

        // R10 unknown command makes following bytes inert
        w0 = wr_cnt; r0 = rd_cnt;
        sel_begin(); sbyte(8'h55, r); sbyte(8'h09, r); sbyte(8'h00, r); sel_end();
        check(cfg_q == 8'h3C && wr_cnt == w0 && rd_cnt == r0, "R10 unknown command",
              cfg_q, 8'h3C);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule